// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time and date for a chip that is fed from a 32.768 kHz reference. The reference reaches the block as a one-cycle enable, `osc_tick_i`, in the system clock domain. A binary prescaler divides that enable down to whole seconds. Above the prescaler sits a BCD calendar that holds second, minute, hour, date, day of week, month and a two-digit year. A millisecond reading is derived from the prescaler phase.

Software reaches every field through a small byte-wide register port. Writes go in on a clock edge and reads come back combinationally. The time fields are guarded by an unlock bit.

Two interrupt outputs are provided. The alarm pulse fires when the calendar steps onto a time that equals the programmed alarm in every enabled field. Once enabled, it needs no further bus activity, so it can serve as a wake-up source from the deepest power state. The tick pulse repeats at a programmable multiple of 1/128 second.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, sec/min/hour/year read 8'h00 and date/day-of-week/month read 8'h01. The control register, the millisecond field and both interrupt outputs are 0.
- R2: The seconds field advances once per 2**DIV_BITS cycles with `osc_tick_i` high. Cycles with `osc_tick_i` low change no time field.
- R3: The millisecond value is floor(P*1000/2**DIV_BITS), where P is the prescaler count. Its low two BCD digits read at address 1 and its hundreds digit at address 2 bits [3:0]. An unlocked write to address 1 or 2 clears the prescaler.
- R4: The time fields are BCD and cascade with digit carries. Seconds and minutes wrap 59→00, hours wrap 23→00, and the year wraps 99→00 into the month rollover. Day of week (address 7) counts 1..7 and wraps 7→1 on each new day.
- R5: Months 04, 06, 09 and 11 have 30 days, and month 02 has 29 days in a leap year and 28 otherwise. All other months have 31 days. A year is a leap year when its value is divisible by 4, and 00 counts as a leap year.
- R6: Writes to time fields take effect only while control bit 0 (address 0) is 1. These fields are the msec addresses 1 and 2, sec 3, min 4, hour 5, date 6, day-of-week 7, month 8 and year 9. Otherwise these writes are ignored.
- R7: `alarm_irq_o` is high for exactly one cycle, in the cycle right after the calendar steps onto a time that matches the alarm in all enabled fields. The alarm values sit at addresses 11 to 16: sec, min, hour, date, month, year.
- R8: The alarm enable register is address 10. Bits 0 to 5 enable sec, min, hour, date, month and year, and bit 6 is the global enable. A disabled field does not take part in the match. A mismatch in any enabled field, or bit 6 clear, gives no alarm pulse.
- R9: In the tick register (address 17), bit 7 enables the tick and bits [6:0] hold N. While enabled, `tick_irq_o` pulses for one cycle every (N+1)*2**(DIV_BITS-7) ticks. While disabled it stays low.
- R10: Every register reads back on `rdata_o` in the same cycle that `addr_i` selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational |
| alarm_irq_o | output | 1 | One-cycle alarm interrupt pulse |
| tick_irq_o | output | 1 | One-cycle periodic tick pulse |

## Verification
The time fields and `alarm_irq_o` change on the same edge: the edge where the prescaler wraps, which is 2**DIV_BITS enabled ticks after the edge that cleared it. The bench counts exactly 2**DIV_BITS - 1 edges and checks that nothing has moved yet. After one more edge it checks the new calendar and the alarm pulse, and one edge later it checks that the pulse has dropped. The millisecond reading is sampled an exact number of edges after a prescaler clear. The tick period is measured edge by edge between two consecutive pulses. All outputs are sampled at the falling edge, and writes land on the rising edge before the sample.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t RESET_TIME = '{year: 8'h00, mon: 8'h01, dow: 8'h01,
                                         date: 8'h01, hour: 8'h00, min: 8'h00,
                                         sec: 8'h00};

    localparam logic [4:0] A_CTRL  = 5'd0;
    localparam logic [4:0] A_MSL   = 5'd1;
    localparam logic [4:0] A_MSH   = 5'd2;
    localparam logic [4:0] A_SEC   = 5'd3;
    localparam logic [4:0] A_MIN   = 5'd4;
    localparam logic [4:0] A_HOUR  = 5'd5;
    localparam logic [4:0] A_DATE  = 5'd6;
    localparam logic [4:0] A_DOW   = 5'd7;
    localparam logic [4:0] A_MON   = 5'd8;
    localparam logic [4:0] A_YEAR  = 5'd9;
    localparam logic [4:0] A_AEN   = 5'd10;
    localparam logic [4:0] A_ASEC  = 5'd11;
    localparam logic [4:0] A_AMIN  = 5'd12;
    localparam logic [4:0] A_AHOUR = 5'd13;
    localparam logic [4:0] A_ADATE = 5'd14;
    localparam logic [4:0] A_AMON  = 5'd15;
    localparam logic [4:0] A_AYEAR = 5'd16;
    localparam logic [4:0] A_TICK  = 5'd17;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // leap when the two-digit year is a multiple of four (00 included)
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4] == 1'b0)
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t step_second(input rtc_time_t t);
        rtc_time_t r;
        r = t;
        if (t.sec != 8'h59) begin
            r.sec = bcd_inc(t.sec);
        end else begin
            r.sec = 8'h00;
            if (t.min != 8'h59) begin
                r.min = bcd_inc(t.min);
            end else begin
                r.min = 8'h00;
                if (t.hour != 8'h23) begin
                    r.hour = bcd_inc(t.hour);
                end else begin
                    r.hour = 8'h00;
                    r.dow  = (t.dow == 8'h07) ? 8'h01 : bcd_inc(t.dow);
                    if (t.date != last_day(t.mon, t.year)) begin
                        r.date = bcd_inc(t.date);
                    end else begin
                        r.date = 8'h01;
                        if (t.mon != 8'h12) begin
                            r.mon = bcd_inc(t.mon);
                        end else begin
                            r.mon  = 8'h01;
                            r.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                        end
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic [11:0] bin_to_bcd3(input logic [9:0] v);
        int unsigned x;
        x = 32'(v);
        return {4'((x / 100) % 10), 4'((x / 10) % 10), 4'(x % 10)};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_BITS = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_tick_i,
    input  logic                clr_i,
    output logic [DIV_BITS-1:0] count_o,
    output logic                unit_pulse_o,
    output logic                sec_pulse_o
);
    localparam int UNIT_W = DIV_BITS - 7;

    typedef struct packed {
        logic [DIV_BITS-1:0] cnt;
    } ps_state_t;

    ps_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i)
            state_d.cnt = '0;
        else if (osc_tick_i)
            state_d.cnt = state_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign count_o      = state_q.cnt;
    assign unit_pulse_o = osc_tick_i && !clr_i && (&state_q.cnt[UNIT_W-1:0]);
    assign sec_pulse_o  = osc_tick_i && !clr_i && (&state_q.cnt);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_pulse_i,
    input  logic       we_i,
    input  logic [4:0] addr_i,
    input  logic [7:0] wdata_i,
    output rtc_time_t  time_o
);
    typedef struct packed {
        rtc_time_t t;
    } core_state_t;

    core_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (sec_pulse_i)
            state_d.t = step_second(state_q.t);
        if (we_i) begin
            case (addr_i)
                A_SEC:   state_d.t.sec  = wdata_i;
                A_MIN:   state_d.t.min  = wdata_i;
                A_HOUR:  state_d.t.hour = wdata_i;
                A_DATE:  state_d.t.date = wdata_i;
                A_DOW:   state_d.t.dow  = wdata_i;
                A_MON:   state_d.t.mon  = wdata_i;
                A_YEAR:  state_d.t.year = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '{t: RESET_TIME};
        else
            state_q <= state_d;
    end

    assign time_o = state_q.t;
endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_pulse_i,
    input  logic       unit_pulse_i,
    input  rtc_time_t  time_i,
    input  logic       we_i,
    input  logic [4:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [6:0] alm_en_o,
    output rtc_time_t  alm_time_o,
    output logic [7:0] tick_cfg_o,
    output logic       alarm_irq_o,
    output logic       tick_irq_o
);
    typedef struct packed {
        logic [6:0] aen;
        logic [7:0] asec;
        logic [7:0] amin;
        logic [7:0] ahour;
        logic [7:0] adate;
        logic [7:0] amon;
        logic [7:0] ayear;
        logic [7:0] tick_cfg;
        logic [6:0] tick_cnt;
        logic       alarm_irq;
        logic       tick_irq;
    } ev_state_t;

    ev_state_t state_d, state_q;
    rtc_time_t upcoming;
    logic [5:0] field_eq;
    logic       hit;

    always_comb begin
        upcoming = step_second(time_i);
        field_eq = {upcoming.year == state_q.ayear, upcoming.mon == state_q.amon,
                    upcoming.date == state_q.adate, upcoming.hour == state_q.ahour,
                    upcoming.min == state_q.amin, upcoming.sec == state_q.asec};
        hit = state_q.aen[6] && (&(field_eq | ~state_q.aen[5:0]));

        state_d = state_q;
        state_d.alarm_irq = sec_pulse_i && hit;
        state_d.tick_irq  = 1'b0;
        if (state_q.tick_cfg[7] && unit_pulse_i) begin
            if (state_q.tick_cnt == 7'd0) begin
                state_d.tick_irq = 1'b1;
                state_d.tick_cnt = state_q.tick_cfg[6:0];
            end else begin
                state_d.tick_cnt = state_q.tick_cnt - 7'd1;
            end
        end
        if (we_i) begin
            case (addr_i)
                A_AEN:   state_d.aen   = wdata_i[6:0];
                A_ASEC:  state_d.asec  = wdata_i;
                A_AMIN:  state_d.amin  = wdata_i;
                A_AHOUR: state_d.ahour = wdata_i;
                A_ADATE: state_d.adate = wdata_i;
                A_AMON:  state_d.amon  = wdata_i;
                A_AYEAR: state_d.ayear = wdata_i;
                A_TICK: begin
                    state_d.tick_cfg = wdata_i;
                    state_d.tick_cnt = wdata_i[6:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign alm_en_o    = state_q.aen;
    assign alm_time_o  = '{year: state_q.ayear, mon: state_q.amon, dow: 8'h00,
                           date: state_q.adate, hour: state_q.ahour,
                           min: state_q.amin, sec: state_q.asec};
    assign tick_cfg_o  = state_q.tick_cfg;
    assign alarm_irq_o = state_q.alarm_irq;
    assign tick_irq_o  = state_q.tick_irq;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick_i,
    input  logic       wr_en_i,
    input  logic [4:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       alarm_irq_o,
    output logic       tick_irq_o
);
    localparam int PROD_W = DIV_BITS + 10;

    typedef struct packed {
        logic unlock;
    } top_state_t;

    top_state_t state_d, state_q;

    logic                ctrl_unlock;
    logic                ms_clr;
    logic                time_we;
    logic [DIV_BITS-1:0] ps_count;
    logic                unit_pulse;
    logic                sec_pulse;
    logic [PROD_W-1:0]   ms_prod;
    logic [9:0]          ms_bin;
    logic [11:0]         ms_bcd;
    rtc_time_t           cur_time;
    rtc_time_t           alm_time;
    logic [6:0]          alm_en_w;
    logic [7:0]          tick_cfg_w;

    assign ctrl_unlock = state_q.unlock;
    assign ms_clr  = wr_en_i && ctrl_unlock && ((addr_i == A_MSL) || (addr_i == A_MSH));
    assign time_we = wr_en_i && ctrl_unlock && (addr_i >= A_SEC) && (addr_i <= A_YEAR);

    always_comb begin
        state_d = state_q;
        if (wr_en_i && (addr_i == A_CTRL))
            state_d.unlock = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_prescaler (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_tick_i   (osc_tick_i),
        .clr_i        (ms_clr),
        .count_o      (ps_count),
        .unit_pulse_o (unit_pulse),
        .sec_pulse_o  (sec_pulse)
    );

    rtc_time_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_pulse_i (sec_pulse),
        .we_i        (time_we),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .time_o      (cur_time)
    );

    rtc_event_unit u_events (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_pulse_i  (sec_pulse),
        .unit_pulse_i (unit_pulse),
        .time_i       (cur_time),
        .we_i         (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .alm_en_o     (alm_en_w),
        .alm_time_o   (alm_time),
        .tick_cfg_o   (tick_cfg_w),
        .alarm_irq_o  (alarm_irq_o),
        .tick_irq_o   (tick_irq_o)
    );

    assign ms_prod = PROD_W'(ps_count) * PROD_W'(1000);
    assign ms_bin  = ms_prod[PROD_W-1:DIV_BITS];
    assign ms_bcd  = bin_to_bcd3(ms_bin);

    always_comb begin
        case (addr_i)
            A_CTRL:  rdata_o = {7'd0, ctrl_unlock};
            A_MSL:   rdata_o = ms_bcd[7:0];
            A_MSH:   rdata_o = {4'd0, ms_bcd[11:8]};
            A_SEC:   rdata_o = cur_time.sec;
            A_MIN:   rdata_o = cur_time.min;
            A_HOUR:  rdata_o = cur_time.hour;
            A_DATE:  rdata_o = cur_time.date;
            A_DOW:   rdata_o = cur_time.dow;
            A_MON:   rdata_o = cur_time.mon;
            A_YEAR:  rdata_o = cur_time.year;
            A_AEN:   rdata_o = {1'b0, alm_en_w};
            A_ASEC:  rdata_o = alm_time.sec;
            A_AMIN:  rdata_o = alm_time.min;
            A_AHOUR: rdata_o = alm_time.hour;
            A_ADATE: rdata_o = alm_time.date;
            A_AMON:  rdata_o = alm_time.mon;
            A_AYEAR: rdata_o = alm_time.year;
            A_TICK:  rdata_o = tick_cfg_w;
            default: rdata_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       osc_tick_i,
    input logic       wr_en_i,
    input logic [4:0] addr_i,
    input logic       ctrl_unlock,
    input rtc_time_t  cur_time,
    input logic [6:0] alm_en_w,
    input logic [7:0] tick_cfg_w,
    input logic       alarm_irq_o,
    input logic       tick_irq_o
);
    // R2
    time_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick_i && !wr_en_i) |=> $stable(cur_time));

    // R6
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !ctrl_unlock && !osc_tick_i && (addr_i >= A_SEC) && (addr_i <= A_YEAR))
        |=> $stable(cur_time));

    // R7
    alarm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq_o |=> !alarm_irq_o);

    // R8
    alarm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq_o |-> $past(alm_en_w[6]));

    // R9
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq_o |=> !tick_irq_o);

    // R9
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq_o |-> $past(tick_cfg_w[7]));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_tick_i  (osc_tick_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .ctrl_unlock (ctrl_unlock),
    .cur_time    (cur_time),
    .alm_en_w    (alm_en_w),
    .tick_cfg_w  (tick_cfg_w),
    .alarm_irq_o (alarm_irq_o),
    .tick_irq_o  (tick_irq_o)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
    localparam int DIVB  = 10;
    localparam int SECN  = 1 << DIVB;
    localparam int NROWS = 12;

    // {start, expected one second later}, each {year,mon,dow,date,hour,min,sec}
    // R4 carries, R5 month lengths and leap years
    localparam logic [111:0] VEC [NROWS] = '{
        {56'h23_06_03_15_12_34_56, 56'h23_06_03_15_12_34_57},
        {56'h99_12_07_31_23_59_59, 56'h00_01_01_01_00_00_00},
        {56'h23_02_02_28_23_59_59, 56'h23_03_03_01_00_00_00},
        {56'h24_02_03_28_23_59_59, 56'h24_02_04_29_00_00_00},
        {56'h24_02_04_29_23_59_59, 56'h24_03_05_01_00_00_00},
        {56'h00_02_01_28_23_59_59, 56'h00_02_02_29_00_00_00},
        {56'h21_04_05_30_23_59_59, 56'h21_05_06_01_00_00_00},
        {56'h22_01_03_31_23_59_59, 56'h22_02_04_01_00_00_00},
        {56'h18_07_02_14_09_59_59, 56'h18_07_02_14_10_00_00},
        {56'h19_09_01_30_23_59_59, 56'h19_10_02_01_00_00_00},
        {56'h10_11_06_30_23_59_59, 56'h10_12_07_01_00_00_00},
        {56'h20_12_05_30_23_59_59, 56'h20_12_06_31_00_00_00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [4:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       alarm_irq_o;
    logic       tick_irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_calendar #(.DIV_BITS(DIVB)) u_rtc_calendar (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick_i  (osc_tick_i),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .rdata_o     (rdata_o),
        .alarm_irq_o (alarm_irq_o),
        .tick_irq_o  (tick_irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        addr_i = a;
        #1;
        v = rdata_o;
    endtask

    // load a time with the reference stopped, then clear the prescaler with it running
    task automatic arm_time(input logic [55:0] t);
        osc_tick_i = 1'b0;
        wr(5'd0, 8'h01);
        for (int k = 0; k < 7; k++) wr(5'(3 + k), t[8*k +: 8]);
        osc_tick_i = 1'b1;
        wr(5'd1, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int gap;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int k = 0; k < 7; k++) begin
            rd(5'(3 + k), v);
            check("R1 time field", 32'(v), (k >= 3 && k <= 5) ? 32'h01 : 32'h00);
        end
        rd(5'd0, v); check("R1 control", 32'(v), 32'h00);
        rd(5'd1, v); check("R1 msec", 32'(v), 32'h00);
        check("R1 irqs", {30'd0, alarm_irq_o, tick_irq_o}, 32'd0);

        // R6 locked write ignored, R2 no advance without reference
        wr(5'd3, 8'h33);
        repeat (3000) @(negedge clk);
        rd(5'd3, v); check("R6 locked sec write", 32'(v), 32'h00);
        rd(5'd1, v); check("R2 frozen msec", 32'(v), 32'h00);

        // R10 readback of control
        wr(5'd0, 8'h01);
        rd(5'd0, v); check("R10 control readback", 32'(v), 32'h01);

        // R3 millisecond derivation
        osc_tick_i = 1'b1;
        wr(5'd2, 8'h00);
        repeat (100) @(negedge clk);
        rd(5'd1, v); check("R3 msec low at 100", 32'(v), 32'h97);
        rd(5'd2, v); check("R3 msec high at 100", 32'(v), 32'h00);
        repeat (412) @(negedge clk);
        rd(5'd1, v); check("R3 msec low at 512", 32'(v), 32'h00);
        rd(5'd2, v); check("R3 msec high at 512", 32'(v), 32'h05);

        // table walk: R2 timing, R4 carries, R5 month lengths
        for (int r = 0; r < NROWS; r++) begin
            arm_time(VEC[r][111:56]);
            repeat (SECN - 1) @(negedge clk);
            rd(5'd3, v); check("R2 no step before period", 32'(v), 32'(VEC[r][63:56]));
            @(negedge clk);
            for (int k = 0; k < 7; k++) begin
                rd(5'(3 + k), v);
                check("R4 R5 rollover field", 32'(v), 32'(VEC[r][8*k +: 8]));
            end
            rd(5'd1, v); check("R3 msec after wrap", 32'(v), 32'h00);
        end

        // R7 alarm on sec+min, hour disabled with a non-matching value (R8)
        wr(5'd11, 8'h00); wr(5'd12, 8'h00); wr(5'd13, 8'h07);
        wr(5'd10, 8'h43);
        rd(5'd10, v); check("R10 alarm enable readback", 32'(v), 32'h43);
        arm_time(56'h23_06_03_15_12_59_59);
        repeat (SECN - 1) @(negedge clk);
        check("R7 alarm not early", 32'(alarm_irq_o), 32'd0);
        @(negedge clk);
        check("R7 alarm fires", 32'(alarm_irq_o), 32'd1);
        @(negedge clk);
        check("R7 alarm one cycle", 32'(alarm_irq_o), 32'd0);

        // R8 mismatch in an enabled field
        wr(5'd12, 8'h05);
        rd(5'd12, v); check("R10 alarm min readback", 32'(v), 32'h05);
        arm_time(56'h23_06_03_15_12_59_59);
        repeat (SECN) @(negedge clk);
        check("R8 mismatch no alarm", 32'(alarm_irq_o), 32'd0);

        // R8 global enable clear
        wr(5'd12, 8'h00);
        wr(5'd10, 8'h03);
        arm_time(56'h23_06_03_15_12_59_59);
        repeat (SECN) @(negedge clk);
        check("R8 global off no alarm", 32'(alarm_irq_o), 32'd0);

        // R9 tick period with N=3
        osc_tick_i = 1'b1;
        wr(5'd17, 8'h83);
        seen = 0;
        for (int i = 0; i < 300 && !tick_irq_o; i++) @(negedge clk);
        gap = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            gap++;
            if (tick_irq_o) break;
        end
        check("R9 tick period", 32'(gap), 32'(4 * (1 << (DIVB - 7))));

        // R9 tick disabled
        wr(5'd17, 8'h03);
        rd(5'd17, v); check("R10 tick readback", 32'(v), 32'h03);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (tick_irq_o) seen++;
        end
        check("R9 tick disabled", 32'(seen), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule